// File: doc/BRIEF.md
# Newest Configuration Record Scanner

This block finds the most recent configuration record in a flash sector that is used as an append-only log. Records are written one page at a time, starting from the top of the sector and moving down, so the sector never needs erasing until every page is used. The scanner walks the opposite way, from the lowest page upward. The first page it reaches that holds a valid record is therefore the newest one.

Each page is fetched with its own SPI read transaction: command 0x03, a 24-bit address, then the page bytes. While the bytes arrive, the scanner checks whether the page is blank (every byte 0xFF), whether it carries a record marker, and whether its 16-bit additive checksum matches. The result is either the index of the newest valid page, or a flag saying no valid page exists, for example after an erase that was cut short. In that case the built-in default configuration applies.

A scan begins with a one-cycle `start` pulse and ends with a one-cycle `done` pulse. At that pulse, `found` and `page_idx` carry the result, and they keep it until the next scan. The sector holds `PAGES` pages of `PAGE_BYTES` bytes each (16 × 256 by default) and begins at address `sector_base`.

Top module: `cfg_log_scanner`

## Requirements
- R1: After reset the block is idle: `spi_cs_n`=1, `spi_sck`=0, `busy`=0, `done`=0, `found`=0, `page_idx`=0.
- R2: Each page read is a separate transaction in SPI mode 0, with SCK at half the clock rate. Chip select falls, then 8 command bits 0x03 and 24 address bits are sent MSB first, each bit held for one low and one high SCK cycle. Then 8·`PAGE_BYTES` data bits are clocked in MSB first, sampled on SCK rising. Chip select rises for exactly one cycle between consecutive pages, and SCK is low whenever chip select is high.
- R3: Pages are read in ascending order starting at page 0. Page k is read at address `sector_base` + k·`PAGE_BYTES`. The scan stops after the first valid page.
- R4: A page whose bytes are all 0xFF is blank. It is skipped and the scan continues with the next page.
- R5: A page is valid only if all three hold: byte 0 is 0xA5; byte 1 is 0x5A; and the 16-bit wrapping sum of bytes 0 to `PAGE_BYTES`-3 equals byte `PAGE_BYTES`-2 (low half) plus 256 × byte `PAGE_BYTES`-1 (high half). A non-blank page that fails any of these is skipped.
- R6: When a valid page is found, `done` pulses with `found`=1 and `page_idx` equal to the index of the lowest valid page.
- R7: When no page is valid, all `PAGES` pages are read, then `done` pulses with `found`=0 and `page_idx`=0.
- R8: `done` is high for exactly one cycle, the cycle after chip select rises following the last page read. `found` and `page_idx` change only at that pulse and hold their values afterwards.
- R9: `busy` is high from the cycle after `start` is accepted through the `done` cycle. A `start` pulse seen while `busy` is high has no effect on the scan.
- R10: A scan never opens more than `PAGES` chip-select transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (one-cycle pulse, accepted when idle) |
| sector_base | input | 24 | Byte address of page 0 of the log sector |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse marking the end of a scan |
| found | output | 1 | A valid record was found in the last scan |
| page_idx | output | IDX_W (4) | Index of the newest valid page, 0 when none |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Command and address to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
The assertions check the following on every cycle:
- SCK stays low while chip select is high, and the block stays quiet while idle.
- Each transaction opens with the command's leading 0 bit.
- `done` is a single-cycle pulse with chip select high, and the result holds between pulses.
- `busy` does not drop before `done`.
- The number of transactions per scan stays within bound.

Page order, exact addresses, the bit-level timing of each transaction, and the choice between blank, invalid and valid pages can only be shown by the bench scenarios. The bench compares every output against a cycle-accurate expected trace, built from a behavioural flash model holding a mix of blank, corrupt and valid pages.

// File: rtl/cfg_log_scanner.sv
module cfg_log_scanner #(
  parameter int PAGES = 16,
  parameter int PAGE_BYTES = 256,
  parameter int IDX_W = $clog2(PAGES),
  parameter logic [7:0] RD_CMD = 8'h03,
  parameter logic [15:0] MARKER = 16'hA55A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      sector_base,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [IDX_W-1:0] page_idx,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int BIT_W  = $clog2(PAGE_BYTES * 8);
  localparam int BYTE_W = $clog2(PAGE_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_EVAL, S_DONE} st_t;
  st_t st;

  logic [31:0]      sh;
  logic [BIT_W-1:0] bcnt;
  logic [IDX_W-1:0] pg;
  logic [7:0]       rx, and_acc;
  logic [15:0]      sum, ck;
  logic             mk_ok;

  wire [7:0]        byte_n    = {rx[6:0], spi_miso};
  wire [BYTE_W-1:0] byte_i    = bcnt[BIT_W-1:3];
  wire              byte_end  = bcnt[2:0] == 3'd7;
  wire              last_cmd  = bcnt[4:0] == 5'd31;
  wire              last_data = bcnt == BIT_W'(PAGE_BYTES * 8 - 1);
  wire              last_page = pg == IDX_W'(PAGES - 1);
  wire              blank     = and_acc == 8'hFF;
  wire              page_ok   = !blank && mk_ok && (sum == ck);

  wire              go    = (st == S_IDLE && start) || (st == S_EVAL && !page_ok && !last_page);
  wire [IDX_W-1:0]  go_pg = (st == S_IDLE) ? '0 : pg + IDX_W'(1);
  wire [23:0]       go_ad = sector_base + 24'(go_pg) * 24'(PAGE_BYTES);

  assign busy     = st != S_IDLE;
  assign done     = st == S_DONE;
  assign spi_mosi = (st == S_CMD) ? sh[31] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      bcnt     <= '0;
      pg       <= '0;
      rx       <= '0;
      and_acc  <= 8'hFF;
      sum      <= '0;
      ck       <= '0;
      mk_ok    <= 1'b0;
      found    <= 1'b0;
      page_idx <= '0;
      spi_cs_n <= 1'b1;
      spi_sck  <= 1'b0;
    end else if (go) begin
      st       <= S_CMD;
      pg       <= go_pg;
      sh       <= {RD_CMD, go_ad};
      bcnt     <= '0;
      and_acc  <= 8'hFF;
      sum      <= '0;
      ck       <= '0;
      mk_ok    <= 1'b0;
      spi_cs_n <= 1'b0;
      spi_sck  <= 1'b0;
    end else begin
      case (st)
        S_CMD: begin
          if (!spi_sck) begin
            spi_sck <= 1'b1;
          end else begin
            spi_sck <= 1'b0;
            if (last_cmd) begin
              st   <= S_DATA;
              bcnt <= '0;
            end else begin
              sh   <= sh << 1;
              bcnt <= bcnt + BIT_W'(1);
            end
          end
        end
        S_DATA: begin
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            rx      <= byte_n;
            if (byte_end) begin
              and_acc <= and_acc & byte_n;
              if (byte_i <= BYTE_W'(PAGE_BYTES - 3)) sum <= sum + {8'h00, byte_n};
              if (byte_i == BYTE_W'(0)) mk_ok <= byte_n == MARKER[15:8];
              if (byte_i == BYTE_W'(1)) mk_ok <= mk_ok && (byte_n == MARKER[7:0]);
              if (byte_i == BYTE_W'(PAGE_BYTES - 2)) ck[7:0]  <= byte_n;
              if (byte_i == BYTE_W'(PAGE_BYTES - 1)) ck[15:8] <= byte_n;
            end
          end else begin
            spi_sck <= 1'b0;
            if (last_data) begin
              spi_cs_n <= 1'b1;
              st       <= S_EVAL;
            end else begin
              bcnt <= bcnt + BIT_W'(1);
            end
          end
        end
        S_EVAL: begin
          st       <= S_DONE;
          found    <= page_ok;
          page_idx <= page_ok ? pg : '0;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_log_scanner_chk.sv
module cfg_log_scanner_chk #(
  parameter int PAGES = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             found,
  input logic [IDX_W-1:0] page_idx,
  input logic             spi_cs_n,
  input logic             spi_sck,
  input logic             spi_mosi
);
  logic             cs_q;
  logic [IDX_W+1:0] sel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sel_cnt <= '0;
    end else begin
      cs_q <= spi_cs_n;
      if (!busy) sel_cnt <= '0;
      else if (cs_q && !spi_cs_n) sel_cnt <= sel_cnt + (IDX_W+2)'(1);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n && !spi_sck && !done));
  p_sck_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);
  p_cmd_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !spi_cs_n && cs_q) |-> !spi_mosi);
  p_no_valid_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> page_idx == '0);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && !spi_sck));
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(found) && $stable(page_idx)));
  p_busy_until_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_page_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cnt <= (IDX_W+2)'(PAGES));
endmodule

bind cfg_log_scanner cfg_log_scanner_chk #(.PAGES(PAGES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .found(found),
  .page_idx(page_idx), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/cfg_log_scanner_tb_top.sv
module cfg_log_scanner_tb_top;
  localparam int PAGES = 16;
  localparam int PB    = 16;
  localparam int IW    = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] base = '0;
  logic busy, done, found, cs_n, sck, mosi, miso;
  logic [IW-1:0] idx;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cfg_log_scanner #(.PAGES(PAGES), .PAGE_BYTES(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sector_base(base),
    .busy(busy), .done(done), .found(found), .page_idx(idx),
    .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso)
  );

  logic [7:0] fmem [PAGES*PB];
  int fcnt = 0;
  logic [31:0] fin = '0;
  logic fmiso = 1'b0;
  assign miso = fmiso;

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) fcnt <= 0;
    else begin
      if (fcnt < 32) fin <= {fin[30:0], mosi};
      fcnt <= fcnt + 1;
    end
  end

  always @(negedge sck) begin
    int d, a;
    if (!cs_n && fcnt >= 32) begin
      d = fcnt - 32;
      a = (int'(fin[23:0]) - int'(base) + d / 8) % (PAGES * PB);
      fmiso <= (fin[31:24] == 8'h03) ? fmem[a][7 - (d % 8)] : 1'b0;
    end
  end

  task automatic chk(input string tag, input logic ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic fill_blank();
    for (int i = 0; i < PAGES * PB; i++) fmem[i] = 8'hFF;
  endtask

  task automatic put_valid(input int p, input int seed);
    int s;
    fmem[p*PB] = 8'hA5;
    fmem[p*PB+1] = 8'h5A;
    for (int i = 2; i < PB - 2; i++) fmem[p*PB+i] = 8'((seed * 29 + i * 53 + 128) & 255);
    s = 0;
    for (int i = 0; i < PB - 2; i++) s += int'(fmem[p*PB+i]);
    fmem[p*PB+PB-2] = 8'(s & 255);
    fmem[p*PB+PB-1] = 8'((s >> 8) & 255);
  endtask

  function automatic int newest();
    for (int p = 0; p < PAGES; p++) begin
      bit blank = 1'b1;
      int s = 0;
      for (int i = 0; i < PB; i++) if (fmem[p*PB+i] != 8'hFF) blank = 1'b0;
      if (!blank) begin
        for (int i = 0; i < PB - 2; i++) s += int'(fmem[p*PB+i]);
        if (fmem[p*PB] == 8'hA5 && fmem[p*PB+1] == 8'h5A &&
            16'(s) == {fmem[p*PB+PB-1], fmem[p*PB+PB-2]}) return p;
      end
    end
    return -1;
  endfunction

  task automatic run_scan(input string tag, input int glitch);
    logic [4:0] q[$];
    logic [4:0] got;
    int r, last, first_bad;
    logic [4:0] bad_got, bad_exp;
    logic rf;
    logic [IW-1:0] ri;
    r = newest();
    last = (r < 0) ? PAGES - 1 : r;
    for (int p = 0; p <= last; p++) begin
      logic [31:0] w;
      w = {8'h03, base + 24'(p * PB)};
      for (int b = 31; b >= 0; b--) begin
        q.push_back({1'b0, 1'b0, w[b], 1'b1, 1'b0});
        q.push_back({1'b0, 1'b1, w[b], 1'b1, 1'b0});
      end
      for (int k = 0; k < 8 * PB; k++) begin
        q.push_back(5'b00010);
        q.push_back(5'b01010);
      end
      q.push_back(5'b10010);
    end
    q.push_back(5'b10011);
    q.push_back(5'b10000);
    @(negedge clk); start = 1'b1;
    first_bad = -1; bad_got = '0; bad_exp = '0; rf = 1'b0; ri = '0;
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      got = {cs_n, sck, mosi, busy, done};
      if (got !== q[i] && first_bad < 0) begin
        first_bad = i; bad_got = got; bad_exp = q[i];
      end
      if (i == q.size() - 2) begin rf = found; ri = idx; end
      start = (i == glitch) ? 1'b1 : 1'b0;
    end
    chk(tag, first_bad < 0, $sformatf("trace {cs,sck,mosi,busy,done} cycle %0d", first_bad),
        32'(bad_got), 32'(bad_exp));
    chk(tag, rf === (r >= 0), "found", 32'(rf), 32'(r >= 0));
    chk(tag, ri === IW'((r < 0) ? 0 : r), "page_idx", 32'(ri), 32'((r < 0) ? 0 : r));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    fill_blank();
    repeat (3) @(negedge clk);
    chk("R1", cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0 && done === 1'b0 &&
        found === 1'b0 && idx === '0, "reset outputs {cs,sck,busy,done,found,idx}",
        {23'd0, cs_n, sck, busy, done, found, idx}, {23'd0, 5'b10000, 4'd0});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7, R4: every page blank, full sector read, default flagged
    fill_blank();
    run_scan("R7_all_blank", -1);

    // R6, R3: newest record is the lowest written page
    fill_blank();
    put_valid(13, 1); put_valid(14, 2); put_valid(15, 3);
    run_scan("R6_newest_13", -1);

    // R3: only the topmost page written
    fill_blank();
    put_valid(15, 4);
    run_scan("R3_top_only", -1);

    // R6: full log, page 0 newest, scan stops at once
    fill_blank();
    for (int p = 0; p < PAGES; p++) put_valid(p, p + 5);
    run_scan("R6_full_log", -1);

    // R5: bad checksum skipped
    fill_blank();
    put_valid(4, 7); fmem[4*PB+PB-2] = fmem[4*PB+PB-2] ^ 8'h01;
    put_valid(7, 8);
    run_scan("R5_bad_sum", -1);

    // R5: wrong or reversed marker skipped
    fill_blank();
    put_valid(2, 9); fmem[2*PB+1] = 8'h5B;
    put_valid(3, 10); fmem[3*PB] = 8'h5A; fmem[3*PB+1] = 8'hA5;
    put_valid(11, 11);
    run_scan("R5_bad_marker", -1);

    // R5: checksum stored big-endian is rejected
    fill_blank();
    put_valid(6, 12);
    begin
      logic [7:0] t;
      t = fmem[6*PB+PB-2]; fmem[6*PB+PB-2] = fmem[6*PB+PB-1]; fmem[6*PB+PB-1] = t;
    end
    put_valid(8, 13);
    run_scan("R5_swapped_sum", -1);

    // R4: one non-0xFF byte makes a non-blank invalid page, nothing valid
    fill_blank();
    fmem[9*PB+5] = 8'hFE;
    run_scan("R4_one_byte", -1);

    // R3: nonzero sector base shifts every address
    base = 24'h3A5000;
    fill_blank();
    put_valid(9, 14);
    run_scan("R3_base", -1);

    // R9: start while busy is ignored
    run_scan("R9_busy_start", 150);

    // R8: result held while idle
    repeat (25) begin
      @(negedge clk);
      chk("R8_hold", found === 1'b1 && idx === IW'(9) && done === 1'b0,
          "idle {found,idx,done}", {27'd0, found, idx}, {27'd0, 1'b1, 4'd9});
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule